// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block drives a single serial output line with asynchronous characters. Each character is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. A one-cycle `bit_tick` pulse from an external rate divider marks every bit boundary. The line changes only on such a pulse.

A byte written through the write strobe lands in a one-deep holding register. The holding register is copied into the shifter when a character starts, so the next byte can be loaded while the current one is on the wire. Two flags report progress. `hold_empty` shows that the holding register may be written. `tx_done` shows that the line has gone quiet with nothing more to send.

Two other line patterns are supported. When the transmitter is switched on, it first sends one full character of ones as a preamble. While the break request is held, it sends whole characters of zeros with no framing bits.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_done` is 1. While `tx_en` is 0 and no character is in progress, `txd` stays 1.
- R2: With `long_char`=0, a data character is 10 bit times long. Bit 0 on the wire is 0 (the start bit), bits 1..8 are `wr_byte` bits 0..7, and bit 9 is 1 (the stop bit). `txd` changes only in a clock cycle in which `bit_tick` was 1.
- R3: With `long_char`=1 (sampled when a character starts), a data character is 11 bit times long. Wire bit 9 carries `bit9` as sampled when the character starts, and wire bit 10 is the stop bit 1.
- R4: When `tx_en` rises, the first character sent is a preamble of all ones lasting one full character length, before any break or data.
- R5: A write strobe clears `hold_empty`. `hold_empty` becomes 1 again exactly when the held byte moves into the shifter, on the tick that starts its start bit.
- R6: If the holding register is full when a stop bit ends, the next start bit follows immediately with no idle bit in between.
- R7: `tx_done` goes to 0 on the tick that starts any character (preamble, break or data). It goes to 1 on the tick that ends a character when nothing follows.
- R8: While `brk_req` is 1 and `tx_en` is 1, whole characters of zeros are sent back to back, 10 or 11 bit times according to `long_char`. Break takes priority over a pending data byte.
- R9: If `brk_req` falls during a break character, that character completes. The line then stays 1 for at least one bit time, and exactly one if a byte is pending.
- R10: Clearing `tx_en` mid-character lets that character finish. The line then stays 1, and a byte written while disabled stays held (`hold_empty` stays 0) until re-enable. Re-enable sends the preamble and then that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| long_char | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit9 | input | 1 | Ninth data bit for long characters |
| brk_req | input | 1 | Send break characters while high |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_byte | input | DATA_W | Byte to load into the holding register |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register may be written |
| tx_done | output | 1 | Line quiet, nothing left to send |

## Verification
The hardest situation to reach is the release of a break request partway through the second of two back-to-back break characters while a byte is already waiting. Three things must then happen in order: the break character finishes, exactly one idle bit follows, and the held byte starts. The bench gets there by raising the break and writing the byte on the same edge. It then drops the request from inside its bit-capture loop at a fixed bit index, and compares the whole captured line pattern. Disabling mid-frame with a byte pending is reached the same way, by a hook on a bit index.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_BRK  = 2'd3
  } tx_state_e;

  // bit times in one character: start + data bits (+ ninth) + stop
  function automatic int unsigned char_len(input int unsigned dw, input logic long_sel);
    return dw + (long_sel ? 32'd3 : 32'd2);
  endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_empty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_empty <= 1'b1;
    end else if (wr_stb) begin
      hold_data  <= wr_byte;
      hold_empty <= 1'b0;
    end else if (take) begin
      hold_empty <= 1'b1;
    end
  end

  // R5: the engine only takes a byte that is present
  p_take_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !hold_empty);

  // R5: empty only re-asserts because of a transfer into the shifter
  p_empty_by_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(take));

endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              long_char,
  input  logic              bit9,
  input  logic              brk_req,
  input  logic              hold_empty,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              char_start,
  output logic              txd,
  output logic              tx_done
);

  localparam int SH_W    = DATA_W + 2;
  localparam int LEN_MAX = DATA_W + 3;
  localparam int CNT_W   = $clog2(LEN_MAX);

  tx_state_e        state, nxt;
  logic [CNT_W-1:0] cnt;       // bit times left after the current one
  logic [SH_W-1:0]  sh;
  logic             en_q, pre_pend;
  logic             pre_need, at_end, can_pick, go_idle;

  // bits following the start bit, first on the wire in bit 0
  function automatic logic [SH_W-1:0] frame_tail(input logic [DATA_W-1:0] d,
                                                 input logic l, input logic b);
    return {1'b1, (l ? b : 1'b1), d};
  endfunction

  assign pre_need = tx_en && (pre_pend || !en_q);
  assign at_end   = (state != ST_IDLE) && (cnt == '0);
  assign can_pick = bit_tick && ((state == ST_IDLE) || at_end);

  always_comb begin
    nxt = ST_IDLE;
    if (can_pick && tx_en && !((state == ST_BRK) && !brk_req)) begin
      if (pre_need)         nxt = ST_PRE;
      else if (brk_req)     nxt = ST_BRK;
      else if (!hold_empty) nxt = ST_DATA;
    end
  end

  assign char_start = (nxt != ST_IDLE);
  assign take       = (nxt == ST_DATA);
  assign go_idle    = bit_tick && at_end && !char_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '1;
      txd      <= 1'b1;
      tx_done  <= 1'b1;
      en_q     <= 1'b0;
      pre_pend <= 1'b0;
    end else begin
      en_q     <= tx_en;
      pre_pend <= pre_need && (nxt != ST_PRE);
      if (char_start) begin
        state   <= nxt;
        cnt     <= CNT_W'(char_len(DATA_W, long_char) - 1);
        txd     <= (nxt == ST_PRE);
        tx_done <= 1'b0;
        sh      <= (nxt == ST_DATA) ? frame_tail(hold_data, long_char, bit9) : '1;
      end else if (go_idle) begin
        state   <= ST_IDLE;
        txd     <= 1'b1;
        tx_done <= 1'b1;
      end else if (bit_tick && (state != ST_IDLE)) begin
        cnt <= cnt - CNT_W'(1);
        txd <= (state == ST_BRK) ? 1'b0 : sh[0];
        sh  <= {1'b1, sh[SH_W-1:1]};
      end
    end
  end

  // R2: line moves only on bit boundaries
  p_txd_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // R2: a data character opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

  // R7: any character start clears the completion flag
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |=> !tx_done);

  // R1: quiet state keeps the line high and reports completion
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (txd && tx_done));

  // R8: break characters are all zeros
  p_brk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRK) |-> !txd);

  // R10: disabled and idle means nothing starts
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !tx_en) |=> ((state == ST_IDLE) && txd));

endmodule

// File: rtl/async_tx.sv
module async_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              long_char,
  input  logic              bit9,
  input  logic              brk_req,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done
);

  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              char_start;

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_byte    (wr_byte),
    .take       (take),
    .hold_data  (hold_data),
    .hold_empty (hold_empty)
  );

  async_tx_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_en      (tx_en),
    .long_char  (long_char),
    .bit9       (bit9),
    .brk_req    (brk_req),
    .hold_empty (hold_empty),
    .hold_data  (hold_data),
    .take       (take),
    .char_start (char_start),
    .txd        (txd),
    .tx_done    (tx_done)
  );

  // R7: starting a character while the flag already says done must drop it
  p_start_drops_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_start && tx_done) |=> !tx_done);

endmodule

// File: tb/test_async_tx.sv
module test_async_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       long_char = 1'b0;
  logic       bit9 = 1'b0;
  logic       brk_req = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       txd, hold_empty, tx_done;

  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;

  logic [63:0] s, ds, es;
  int          hook_i = -1;
  int          hook_kind = 0;
  logic [7:0]  hook_byte = '0;
  logic        hook_b9 = 1'b0;

  async_tx #(.DATA_W(8)) i_async_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .long_char(long_char), .bit9(bit9), .brk_req(brk_req),
    .wr_stb(wr_stb), .wr_byte(wr_byte),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  always #5 clk = ~clk;

  // bit rate: one tick every 6 clocks
  always @(negedge clk) begin
    tcnt     <= (tcnt == 5) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == 5);
  end

  function automatic logic [63:0] ones(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  // wire pattern of one data character, bit 0 first
  function automatic logic [63:0] frame(input logic [7:0] d, input logic l, input logic b);
    logic [63:0] f;
    f = '0;
    f[8:1] = d;
    if (l) begin f[9] = b; f[10] = 1'b1; end
    else   f[9] = 1'b1;
    return f;
  endfunction

  function automatic int flen(input logic l);
    return l ? 11 : 10;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    wr_byte = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic do_hook();
    case (hook_kind)
      1: brk_req = 1'b0;
      2: tx_en   = 1'b0;
      3: begin bit9 = hook_b9; write(hook_byte); end
      default: ;
    endcase
  endtask

  task automatic cap(input int n);
    s = '0; ds = '0; es = '0;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      s[i]  = txd;
      ds[i] = tx_done;
      es[i] = hold_empty;
      if (i == hook_i) do_hook();
    end
    hook_i = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] e;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", {63'd0, txd}, 64'd1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", {63'd0, hold_empty}, 64'd1);
    chk(tx_done == 1'b1, "R7 tx_done after reset", {63'd0, tx_done}, 64'd1);

    // R10 disabled: write is held, line stays high
    wait_tick();
    write(8'hA5);
    cap(15);
    chk(s == ones(15), "R10 line high while disabled", s, ones(15));
    chk(hold_empty == 1'b0, "R5 write clears hold_empty", {63'd0, hold_empty}, 64'd0);

    // R4 enable: preamble then held byte
    tx_en = 1'b1;
    cap(20);
    e = ones(10) | (frame(8'hA5, 1'b0, 1'b0) << 10);
    chk(s == e, "R4 preamble then frame", s, e);
    chk(ds[2] == 1'b0, "R7 done low during preamble", {63'd0, ds[2]}, 64'd0);
    chk(es[9] == 1'b0 && es[10] == 1'b1, "R5 empty set at transfer", {62'd0, es[10], es[9]}, 64'd2);
    wait_tick();
    chk(tx_done == 1'b1 && txd == 1'b1, "R7 done after last stop", {62'd0, tx_done, txd}, 64'd3);

    // R3 R6 back-to-back long characters
    long_char = 1'b1; bit9 = 1'b1;
    write(8'h3C);
    hook_i = 1; hook_kind = 3; hook_byte = 8'hC3; hook_b9 = 1'b0;
    cap(22);
    e = frame(8'h3C, 1'b1, 1'b1) | (frame(8'hC3, 1'b1, 1'b0) << 11);
    chk(s == e, "R3 R6 two long frames no gap", s, e);
    chk(ds[11] == 1'b0, "R6 done stays low between frames", {63'd0, ds[11]}, 64'd0);
    chk(es[2] == 1'b0 && es[11] == 1'b1, "R5 second write and transfer", {62'd0, es[11], es[2]}, 64'd2);
    wait_tick();
    chk(tx_done == 1'b1, "R7 done after pair", {63'd0, tx_done}, 64'd1);

    // R2 R3 random characters
    for (int k = 0; k < 12; k++) begin
      logic [7:0] d;
      logic l, b;
      d = 8'($urandom);
      l = 1'($urandom);
      b = 1'($urandom);
      long_char = l; bit9 = b;
      write(d);
      cap(flen(l));
      e = frame(d, l, b);
      chk(s == e, l ? "R3 random long frame" : "R2 random short frame", s, e);
    end

    // R8 R9 break with a byte waiting, released inside second break char
    long_char = 1'b0;
    brk_req = 1'b1;
    write(8'h5A);
    hook_i = 13; hook_kind = 1;
    cap(31);
    e = (64'd1 << 20) | (frame(8'h5A, 1'b0, 1'b0) << 21);
    chk(s == e, "R8 R9 break twice, one idle bit, then byte", s, e);
    chk(ds[5] == 1'b0, "R7 done low during break", {63'd0, ds[5]}, 64'd0);

    // R8 R9 long break released early: 11 zeros then idle
    wait_tick();
    long_char = 1'b1;
    brk_req = 1'b1;
    hook_i = 3; hook_kind = 1;
    cap(22);
    e = ones(11) << 11;
    chk(s == e, "R8 long break length then idle", s, e);
    chk(ds[12] == 1'b1, "R7 done after break", {63'd0, ds[12]}, 64'd1);

    // R10 disable mid-frame
    long_char = 1'b0;
    write(8'h81);
    hook_i = 3; hook_kind = 2;
    cap(25);
    e = frame(8'h81, 1'b0, 1'b0) | (ones(15) << 10);
    chk(s == e, "R10 frame finishes after disable", s, e);
    write(8'h7E);
    cap(12);
    chk(s == ones(12), "R10 held byte not sent while disabled", s, ones(12));
    chk(es == 64'd0, "R10 hold stays full while disabled", es, 64'd0);
    tx_en = 1'b1;
    cap(20);
    e = ones(10) | (frame(8'h7E, 1'b0, 1'b0) << 10);
    chk(s == e, "R4 R10 re-enable preamble then byte", s, e);

    summary();
    $finish;
  end

endmodule